// File: doc/BRIEF.md
# UART Host Register Bank with Word Queues

This block sits between a 16-bit memory-mapped host port and a pair of serial engines, one for transmit and one for receive. It holds the line settings of each engine, a baud divisor for each direction, and a word queue for each direction. The host fills the transmit queue one word at a time and empties the receive queue one word at a time. The serial engines stay outside the block and connect to it through its ports.

A queue operation is not caused by the access to the data register. The host first writes the word into a holding register. It then writes 1 to a strobe bit in the queue control register and later writes 0 to that bit. Only the 0-to-1 change moves a word. When the transmit path is out of reset, sending is enabled, the queue holds a word and the engine reports idle, the block presents the word at the queue head to the engine together with a one-cycle start pulse. Each word that the receive engine finishes is appended to the receive queue. Each queue control register reports empty, full and the word count.

The host addresses registers by halfword index, which is the byte offset divided by two. Index 0 is transmit setup, 1 the transmit divisor, 2 the transmit queue control, 3 the transmit holding word, 4 receive setup, 5 the receive divisor, 6 the receive queue control and 7 the receive data word. Read data is registered and returns one cycle after the index is presented.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, transmit setup reads 0x01C1: hold-reset bit 0 is 1 and word length minus one is 7 in bits 10:6. Receive setup reads 0x0700: hold-reset is 0 and length minus one is 7 in bits 12:8. Both divisors read 0, and both queue controls read 0x0002 (empty).
- R2: Writable fields appear on the configuration ports and in read-back. Transmit setup uses bit 1 for send enable, bit 3 for parity enable, bit 4 for odd parity and bit 5 for two stop bits. Receive setup uses the same bit positions, with receive enable in bit 1. A write to a divisor appears on its divisor port.
- R3: A push or a pop happens only when bit 0 of a queue control register changes from 0 to 1 through a host write. Writing 1 again while the bit is already 1 moves no word. Bit 0 reads back the last value written.
- R4: A push into a full queue is dropped, and the count and contents stay unchanged.
- R5: While transmit hold-reset is 1, the transmit queue is emptied, pushes are dropped and no start pulse is issued.
- R6: A start pulse lasts one cycle. It is issued when hold-reset is 0, send enable is 1, the queue is not empty, engine busy is low and no start pulse was issued in the previous cycle. Words go out in push order.
- R7: Each cycle with rx_valid high appends rx_word to the receive queue. A pop loads the head word into the data register at index 7. Bit 7 of receive setup is 1 exactly when the receive queue is not empty.
- R8: A pop from an empty receive queue leaves the data register unchanged.
- R9: Receive setup bit 6 is set by a pulse on rx_frame_err and stays set. A host write with bit 6 at 1 clears it, and a write with bit 6 at 0 leaves it set.
- R10: Host writes do not change the busy bit (bit 2 of each setup register) or the empty, full and count bits. The busy bit always reads the engine's busy input.
- R11: While receive hold-reset is 1, the receive queue is emptied and incoming words are dropped.
- R12: In each queue control register, bit 1 is empty, bit 2 is full and bits 8:3 are the word count, from 0 up to the queue depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_hw_addr | input | 3 | Halfword register index |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the index presented in the previous cycle |
| tx_hold_rst | output | 1 | Holds the transmit engine in reset |
| tx_send_en | output | 1 | Transmit enable |
| tx_parity_en | output | 1 | Transmit parity on |
| tx_parity_odd | output | 1 | Transmit parity is odd |
| tx_two_stop | output | 1 | Transmit uses two stop bits |
| tx_len_m1 | output | 5 | Transmit word length minus one |
| tx_clk_div | output | 16 | Transmit baud divisor |
| tx_start | output | 1 | One-cycle start pulse to the engine |
| tx_word | output | 16 | Word to send, valid with tx_start |
| tx_busy | input | 1 | Transmit engine busy |
| rx_hold_rst | output | 1 | Holds the receive engine in reset |
| rx_recv_en | output | 1 | Receive enable |
| rx_parity_en | output | 1 | Receive parity on |
| rx_parity_odd | output | 1 | Receive parity is odd |
| rx_two_stop | output | 1 | Receive expects two stop bits |
| rx_len_m1 | output | 5 | Receive word length minus one |
| rx_clk_div | output | 16 | Receive baud divisor |
| rx_busy | input | 1 | Receive engine busy |
| rx_valid | input | 1 | Completed receive word present |
| rx_word | input | 16 | Completed receive word |
| rx_frame_err | input | 1 | Frame error pulse from the engine |

## Verification
A strobe level that stays stale after a write shows up in two ways. Bit 0 of the queue control register reads back wrong, and a later write of 1 pushes or pops one word too many or too few. The count field reveals this in the read issued on the cycle after that write. A wrong queue pointer shows up as a word sent out of order, or as a wrong value at the receive data index on the next pop. A missing start guard gives two start pulses on consecutive cycles, which the cycle-by-cycle comparison catches on the second cycle.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int unsigned LEN_W = 5;

  typedef struct packed {
    logic             hold_rst;
    logic             run_en;
    logic             par_en;
    logic             par_odd;
    logic             two_stop;
    logic [LEN_W-1:0] len_m1;
  } ser_cfg_t;

  typedef enum logic [2:0] {
    RG_TX_SET  = 3'd0,
    RG_TX_DIV  = 3'd1,
    RG_TX_FIFO = 3'd2,
    RG_TX_DATA = 3'd3,
    RG_RX_SET  = 3'd4,
    RG_RX_DIV  = 3'd5,
    RG_RX_FIFO = 3'd6,
    RG_RX_DATA = 3'd7
  } reg_sel_e;

  localparam ser_cfg_t TX_CFG_INIT = '{hold_rst: 1'b1, run_en: 1'b0, par_en: 1'b0,
                                       par_odd: 1'b0, two_stop: 1'b0, len_m1: 5'd7};
  localparam ser_cfg_t RX_CFG_INIT = '{hold_rst: 1'b0, run_en: 1'b0, par_en: 1'b0,
                                       par_odd: 1'b0, two_stop: 1'b0, len_m1: 5'd7};

endpackage

// File: rtl/uart_strobe_edge.sv
module uart_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic level,
  output logic pulse
);

  // A pulse only where the written value turns the stored bit from 0 to 1
  assign pulse = wr_hit && wr_bit && !level;

  always_ff @(posedge clk) begin
    if (rst)         level <= 1'b0;
    else if (wr_hit) level <= wr_bit;
  end

  AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R3

endmodule

// File: rtl/uart_word_fifo.sv
module uart_word_fifo #(
  parameter  int unsigned DEPTH  = 32,
  parameter  int unsigned WORD_W = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_word,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              wr_ok, rd_ok;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign wr_ok = push && !full && !flush;
  assign rd_ok = pop && !empty && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset, so block RAM can hold it
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst)        pop_word <= '0;
    else if (rd_ok) pop_word <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) rptr <= bump(rptr);
      count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH)); // R12
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (full && $stable(count))); // R4
  AST_EMPTY_POP_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (empty && pop) |=> $stable(pop_word)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R5 R11

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,   // at most 63 so the count fits its field
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned DIV_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       bus_hw_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             tx_hold_rst,
  output logic             tx_send_en,
  output logic             tx_parity_en,
  output logic             tx_parity_odd,
  output logic             tx_two_stop,
  output logic [LEN_W-1:0] tx_len_m1,
  output logic [DIV_W-1:0] tx_clk_div,
  output logic             tx_start,
  output logic [BUS_W-1:0] tx_word,
  input  logic             tx_busy,
  output logic             rx_hold_rst,
  output logic             rx_recv_en,
  output logic             rx_parity_en,
  output logic             rx_parity_odd,
  output logic             rx_two_stop,
  output logic [LEN_W-1:0] rx_len_m1,
  output logic [DIV_W-1:0] rx_clk_div,
  input  logic             rx_busy,
  input  logic             rx_valid,
  input  logic [BUS_W-1:0] rx_word,
  input  logic             rx_frame_err
);

  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
  localparam int unsigned CNT_FLD = 6;

  reg_sel_e          sel;
  ser_cfg_t          tx_cfg_q, rx_cfg_q;
  logic [DIV_W-1:0]  tx_div_q, rx_div_q;
  logic [BUS_W-1:0]  tx_hold_q;
  logic              ferr_q;
  logic              tx_start_q;
  logic              launch;
  logic              txs_level, txs_pulse, rxs_level, rxs_pulse;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [BUS_W-1:0]  rx_data;
  logic [CNT_FLD-1:0] tx_cnt_f, rx_cnt_f;
  logic [BUS_W-1:0]  rd_mux;

  assign sel = reg_sel_e'(bus_hw_addr);

  function automatic logic hit(input reg_sel_e s, input reg_sel_e r, input logic we);
    return we && (s == r);
  endfunction

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cfg_q  <= TX_CFG_INIT;
      rx_cfg_q  <= RX_CFG_INIT;
      tx_div_q  <= '0;
      rx_div_q  <= '0;
      tx_hold_q <= '0;
    end else if (bus_we) begin
      case (sel)
        RG_TX_SET:  tx_cfg_q <= '{hold_rst: bus_wdata[0], run_en: bus_wdata[1],
                                  par_en: bus_wdata[3], par_odd: bus_wdata[4],
                                  two_stop: bus_wdata[5], len_m1: bus_wdata[10:6]};
        RG_RX_SET:  rx_cfg_q <= '{hold_rst: bus_wdata[0], run_en: bus_wdata[1],
                                  par_en: bus_wdata[3], par_odd: bus_wdata[4],
                                  two_stop: bus_wdata[5], len_m1: bus_wdata[12:8]};
        RG_TX_DIV:  tx_div_q  <= bus_wdata[DIV_W-1:0];
        RG_RX_DIV:  rx_div_q  <= bus_wdata[DIV_W-1:0];
        RG_TX_DATA: tx_hold_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // sticky frame error: engine set wins over host clear
  always_ff @(posedge clk) begin
    if (rst)                                  ferr_q <= 1'b0;
    else if (rx_frame_err)                    ferr_q <= 1'b1;
    else if (hit(sel, RG_RX_SET, bus_we) && bus_wdata[6]) ferr_q <= 1'b0;
  end

  uart_strobe_edge u_tx_strobe (
    .clk(clk), .rst(rst), .wr_hit(hit(sel, RG_TX_FIFO, bus_we)), .wr_bit(bus_wdata[0]),
    .level(txs_level), .pulse(txs_pulse));

  uart_strobe_edge u_rx_strobe (
    .clk(clk), .rst(rst), .wr_hit(hit(sel, RG_RX_FIFO, bus_we)), .wr_bit(bus_wdata[0]),
    .level(rxs_level), .pulse(rxs_pulse));

  // the gap after each start covers the engine's one-cycle busy latency
  assign launch = !tx_cfg_q.hold_rst && tx_cfg_q.run_en && !tx_empty && !tx_busy && !tx_start_q;

  always_ff @(posedge clk) begin
    if (rst) tx_start_q <= 1'b0;
    else     tx_start_q <= launch;
  end

  uart_word_fifo #(.DEPTH(DEPTH), .WORD_W(BUS_W)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(tx_cfg_q.hold_rst),
    .push(txs_pulse), .push_word(tx_hold_q), .pop(launch), .pop_word(tx_word),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full));

  uart_word_fifo #(.DEPTH(DEPTH), .WORD_W(BUS_W)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(rx_cfg_q.hold_rst),
    .push(rx_valid), .push_word(rx_word), .pop(rxs_pulse), .pop_word(rx_data),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full));

  always_comb begin
    tx_cnt_f = '0;
    rx_cnt_f = '0;
    tx_cnt_f[CNT_W-1:0] = tx_cnt;
    rx_cnt_f[CNT_W-1:0] = rx_cnt;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      RG_TX_SET:  rd_mux[10:0] = {tx_cfg_q.len_m1, tx_cfg_q.two_stop, tx_cfg_q.par_odd,
                                  tx_cfg_q.par_en, tx_busy, tx_cfg_q.run_en, tx_cfg_q.hold_rst};
      RG_TX_DIV:  rd_mux[DIV_W-1:0] = tx_div_q;
      RG_TX_FIFO: rd_mux[8:0] = {tx_cnt_f, tx_full, tx_empty, txs_level};
      RG_TX_DATA: rd_mux = tx_hold_q;
      RG_RX_SET:  rd_mux[12:0] = {rx_cfg_q.len_m1, !rx_empty, ferr_q, rx_cfg_q.two_stop,
                                  rx_cfg_q.par_odd, rx_cfg_q.par_en, rx_busy,
                                  rx_cfg_q.run_en, rx_cfg_q.hold_rst};
      RG_RX_DIV:  rd_mux[DIV_W-1:0] = rx_div_q;
      RG_RX_FIFO: rd_mux[8:0] = {rx_cnt_f, rx_full, rx_empty, rxs_level};
      RG_RX_DATA: rd_mux = rx_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign tx_hold_rst   = tx_cfg_q.hold_rst;
  assign tx_send_en    = tx_cfg_q.run_en;
  assign tx_parity_en  = tx_cfg_q.par_en;
  assign tx_parity_odd = tx_cfg_q.par_odd;
  assign tx_two_stop   = tx_cfg_q.two_stop;
  assign tx_len_m1     = tx_cfg_q.len_m1;
  assign tx_clk_div    = tx_div_q;
  assign tx_start      = tx_start_q;
  assign rx_hold_rst   = rx_cfg_q.hold_rst;
  assign rx_recv_en    = rx_cfg_q.run_en;
  assign rx_parity_en  = rx_cfg_q.par_en;
  assign rx_parity_odd = rx_cfg_q.par_odd;
  assign rx_two_stop   = rx_cfg_q.two_stop;
  assign rx_len_m1     = rx_cfg_q.len_m1;
  assign rx_clk_div    = rx_div_q;

  AST_START_SPACED: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start); // R6
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (rst)
    tx_hold_rst |=> !tx_start); // R5
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |=> bus_rdata[6] || !$past(bus_hw_addr == 3'd4)); // R9

endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_hw_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tx_hold_rst, tx_send_en, tx_parity_en, tx_parity_odd, tx_two_stop;
  logic [4:0]  tx_len_m1, rx_len_m1;
  logic [15:0] tx_clk_div, rx_clk_div, tx_word;
  logic        tx_start;
  logic        tx_busy = 1'b0;
  logic        rx_hold_rst, rx_recv_en, rx_parity_en, rx_parity_odd, rx_two_stop;
  logic        rx_busy = 1'b0, rx_valid = 1'b0, rx_frame_err = 1'b0;
  logic [15:0] rx_word = '0;

  uart_host_regs i_uart_host_regs (
    .clk(clk), .rst(rst), .bus_hw_addr(bus_hw_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_hold_rst(tx_hold_rst), .tx_send_en(tx_send_en), .tx_parity_en(tx_parity_en),
    .tx_parity_odd(tx_parity_odd), .tx_two_stop(tx_two_stop), .tx_len_m1(tx_len_m1),
    .tx_clk_div(tx_clk_div), .tx_start(tx_start), .tx_word(tx_word), .tx_busy(tx_busy),
    .rx_hold_rst(rx_hold_rst), .rx_recv_en(rx_recv_en), .rx_parity_en(rx_parity_en),
    .rx_parity_odd(rx_parity_odd), .rx_two_stop(rx_two_stop), .rx_len_m1(rx_len_m1),
    .rx_clk_div(rx_clk_div), .rx_busy(rx_busy), .rx_valid(rx_valid), .rx_word(rx_word),
    .rx_frame_err(rx_frame_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  logic busy_force = 1'b0;
  int busy_cnt = 0;
  logic [15:0] sent[$];

  // reference model state
  logic [15:0] m_txw, m_rxw, m_txdiv, m_rxdiv, m_hold, m_rxdata, m_txword, exp_rdata;
  logic        m_tstr, m_rstr, m_ferr, m_start;
  logic [15:0] tq[$];
  logic [15:0] rq[$];

  function automatic logic [15:0] fifo_stat(int n, logic strobe);
    logic [5:0] c = 6'(n);
    return {7'd0, c, (n == DEPTH), (n == 0), strobe};
  endfunction

  function automatic logic [15:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return (m_txw & 16'h07FB) | {13'd0, tx_busy, 2'd0};
      3'd1: return m_txdiv;
      3'd2: return fifo_stat(tq.size(), m_tstr);
      3'd3: return m_hold;
      3'd4: return (m_rxw & 16'h1F3B) | {8'd0, (rq.size() > 0), m_ferr, 3'd0, rx_busy, 2'd0};
      3'd5: return m_rxdiv;
      3'd6: return fifo_stat(rq.size(), m_rstr);
      default: return m_rxdata;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_txw = 16'h01C1; m_rxw = 16'h0700; m_txdiv = 0; m_rxdiv = 0; m_hold = 0;
      m_rxdata = 0; m_txword = 0; exp_rdata = 0; m_tstr = 0; m_rstr = 0;
      m_ferr = 0; m_start = 0; tq.delete(); rq.delete();
    end else begin
      logic launch, tpush, rpop;
      int pre;
      exp_rdata = model_read(bus_hw_addr);
      launch = !m_txw[0] && m_txw[1] && tq.size() > 0 && !tx_busy && !m_start;
      tpush = bus_we && bus_hw_addr == 3'd2 && bus_wdata[0] && !m_tstr;
      rpop  = bus_we && bus_hw_addr == 3'd6 && bus_wdata[0] && !m_rstr;
      if (m_txw[0]) begin tq.delete(); launch = 1'b0; end
      else begin
        pre = tq.size();
        if (launch) m_txword = tq.pop_front();
        if (tpush && pre < DEPTH) tq.push_back(m_hold);
      end
      m_start = launch;
      if (m_rxw[0]) rq.delete();
      else begin
        pre = rq.size();
        if (rpop && pre > 0) m_rxdata = rq.pop_front();
        if (rx_valid && pre < DEPTH) rq.push_back(rx_word);
      end
      if (rx_frame_err) m_ferr = 1;
      else if (bus_we && bus_hw_addr == 3'd4 && bus_wdata[6]) m_ferr = 0;
      if (bus_we) case (bus_hw_addr)
        3'd0: m_txw = bus_wdata;
        3'd1: m_txdiv = bus_wdata;
        3'd2: m_tstr = bus_wdata[0];
        3'd3: m_hold = bus_wdata;
        3'd4: m_rxw = bus_wdata;
        3'd5: m_rxdiv = bus_wdata;
        3'd6: m_rstr = bus_wdata[0];
        default: ;
      endcase
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // cycle compare against the model, plus a simple busy engine
  always @(negedge clk) begin
    check(cur_req, "rdata", 32'(bus_rdata), 32'(exp_rdata));
    check(cur_req, "tx_start", 32'(tx_start), 32'(m_start));
    check(cur_req, "tx_word", 32'(tx_word), 32'(m_txword));
    check(cur_req, "tx cfg", {tx_hold_rst, tx_send_en, tx_parity_en, tx_parity_odd, tx_two_stop, tx_len_m1, tx_clk_div},
          {m_txw[0], m_txw[1], m_txw[3], m_txw[4], m_txw[5], m_txw[10:6], m_txdiv});
    check(cur_req, "rx cfg", {rx_hold_rst, rx_recv_en, rx_parity_en, rx_parity_odd, rx_two_stop, rx_len_m1, rx_clk_div},
          {m_rxw[0], m_rxw[1], m_rxw[3], m_rxw[4], m_rxw[5], m_rxw[12:8], m_rxdiv});
    if (tx_start) begin sent.push_back(tx_word); busy_cnt = 4; end
    else if (busy_cnt > 0) busy_cnt--;
    tx_busy = (busy_cnt != 0) || busy_force;
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_hw_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [15:0] exp);
    @(negedge clk); bus_hw_addr = a;
    @(negedge clk); check(req, "read", 32'(bus_rdata), 32'(exp));
  endtask

  task automatic strobe(logic [2:0] a);
    wr(a, 16'h0001); wr(a, 16'h0000);
  endtask

  task automatic rx_in(logic [15:0] w);
    @(negedge clk); rx_valid = 1'b1; rx_word = w;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    idle(3); rst = 1'b0;
    cur_req = "R1";
    rd("R1", 3'd0, 16'h01C1); rd("R1", 3'd4, 16'h0700);
    rd("R1", 3'd2, 16'h0002); rd("R1", 3'd6, 16'h0002); rd("R1", 3'd1, 16'h0000);
    cur_req = "R2";
    wr(3'd1, 16'h1234); rd("R2", 3'd1, 16'h1234); check("R2", "tx_clk_div", 32'(tx_clk_div), 32'h1234);
    wr(3'd5, 16'h0055); rd("R2", 3'd5, 16'h0055);
    wr(3'd4, 16'h0E3A); rd("R2", 3'd4, 16'h0E3A);
    check("R2", "rx cfg port", {rx_recv_en, rx_parity_en, rx_parity_odd, rx_two_stop, rx_len_m1}, {4'b1111, 5'd14});
    wr(3'd4, 16'h0700);
    cur_req = "R10";
    wr(3'd0, 16'h01CD); rd("R10", 3'd0, 16'h01C9);
    wr(3'd2, 16'h0006); rd("R10", 3'd2, 16'h0002);
    cur_req = "R5";
    wr(3'd3, 16'hAAAA); strobe(3'd2); rd("R5", 3'd2, 16'h0002);
    cur_req = "R3";
    wr(3'd0, 16'h01C0);
    wr(3'd3, 16'h1111); wr(3'd2, 16'h0001); wr(3'd2, 16'h0001);
    rd("R3", 3'd2, 16'h0009);
    wr(3'd2, 16'h0000); rd("R3", 3'd2, 16'h0008);
    cur_req = "R4";
    for (int i = 0; i < 31; i++) begin wr(3'd3, 16'h2000 + 16'(i)); strobe(3'd2); end
    rd("R12", 3'd2, 16'h0104);
    wr(3'd3, 16'hBEEF); strobe(3'd2); rd("R4", 3'd2, 16'h0104);
    cur_req = "R6";
    wr(3'd0, 16'h01C2); idle(400);
    check("R6", "sent count", 32'(sent.size()), 32);
    check("R6", "first word", 32'(sent[0]), 32'h1111);
    check("R6", "last word", 32'(sent[31]), 32'h201E);
    rd("R12", 3'd2, 16'h0002);
    cur_req = "R5";
    wr(3'd0, 16'h01C0); strobe(3'd2); strobe(3'd2);
    rd("R12", 3'd2, 16'h0010);
    wr(3'd0, 16'h01C1); rd("R5", 3'd2, 16'h0002);
    n0 = sent.size(); wr(3'd0, 16'h01C2); idle(20);
    check("R5", "no send after flush", 32'(sent.size()), 32'(n0));
    cur_req = "R7";
    rx_in(16'h0A01); rx_in(16'h0A02); rx_in(16'h0A03);
    rd("R7", 3'd4, 16'h0780); rd("R12", 3'd6, 16'h0018);
    strobe(3'd6); rd("R7", 3'd7, 16'h0A01);
    strobe(3'd6); rd("R7", 3'd7, 16'h0A02);
    strobe(3'd6); rd("R7", 3'd7, 16'h0A03);
    rd("R7", 3'd4, 16'h0700);
    cur_req = "R8";
    strobe(3'd6); rd("R8", 3'd7, 16'h0A03);
    cur_req = "R9";
    @(negedge clk); rx_frame_err = 1'b1; @(negedge clk); rx_frame_err = 1'b0;
    rd("R9", 3'd4, 16'h0740);
    wr(3'd4, 16'h0700); rd("R9", 3'd4, 16'h0740);
    wr(3'd4, 16'h0740); rd("R9", 3'd4, 16'h0700);
    cur_req = "R11";
    rx_in(16'h0B01); rx_in(16'h0B02); rd("R11", 3'd6, 16'h0010);
    wr(3'd4, 16'h0701); rd("R11", 3'd6, 16'h0002);
    rx_in(16'h0B03); rd("R11", 3'd6, 16'h0002);
    wr(3'd4, 16'h0700); rd("R11", 3'd6, 16'h0002);
    cur_req = "R10";
    @(negedge clk); busy_force = 1'b1; rx_busy = 1'b1;
    rd("R10", 3'd0, 16'h01C6); rd("R10", 3'd4, 16'h0704);
    wr(3'd4, 16'h0700); rd("R10", 3'd4, 16'h0704);
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule